// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DRAM interface and takes the device from power-on to ready for normal operation. Once the supplies are reported good, it holds the device reset pin low for a minimum time. It keeps NOP on the command bus while the device clock settles and then releases reset. After a long NOP window it writes three mode registers. Each write is a single strobed cycle that carries the register's value on the address bus. The writes are separated by a set-to-set gap and by a settling window for DLL reset and long impedance calibration.

The reset-hold time is given in nanoseconds and converted to clock cycles from a clock-period parameter. Every other window is given directly in cycles. The mode-register values are inputs, so the system can set them. If power-good drops at any moment, the whole sequence restarts and the ready flag is withdrawn.

Top module: `dram_init_seq`

## Requirements
- R1: The command bus `cmd` carries NOP (2'b00) in every cycle except a mode-register write, which carries 2'b01 with `cmdValid` high for exactly one cycle. Outside a write, `mrSel` and `addr` are zero.
- R2: While `pwrGood` is low, and for ceil(RESET_HOLD_NS*1000/CLK_PERIOD_PS) cycles after `pwrGood` is first sampled high, `devResetN` is low.
- R3: After the reset hold, `devResetN` stays low for exactly PRE_NOP_CYCLES more cycles of NOP and then goes high.
- R4: After reset release, exactly POST_NOP_CYCLES NOP cycles pass with `devResetN` high. The first write then follows, with `mrSel`=0 and `addr`=`mr0Val`.
- R5: Exactly MRS_GAP_CYCLES NOP cycles separate the register-0 write from the register-1 write. The register-1 write has `mrSel`=1 and `addr`=`mr1Val`.
- R6: Exactly CAL_CYCLES NOP cycles separate the register-1 write from the register-2 write. The register-2 write has `mrSel`=2 and `addr`=`mr2Val`.
- R7: `initDone` rises in the cycle after the register-2 write. It then stays high, with no further writes, for as long as `pwrGood` stays high.
- R8: `pwrGood` sampled low at any clock edge leaves `devResetN`, `initDone` and `cmdValid` low from the next cycle. When power returns, the sequence restarts from R2.
- R9: While `rstN` is low, `devResetN` and `initDone` are low and the command bus is NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset of the sequencer |
| pwrGood | input | 1 | Supplies stable; low restarts the sequence |
| mr0Val | input | ADDR_W | Value written to mode register 0 |
| mr1Val | input | ADDR_W | Value written to mode register 1 (DLL reset, long calibration) |
| mr2Val | input | ADDR_W | Value written to mode register 2 |
| devResetN | output | 1 | Active-low reset to the DRAM device |
| cmd | output | 2 | Command code: 2'b00 NOP, 2'b01 mode-register set |
| cmdValid | output | 1 | One-cycle strobe marking a mode-register write |
| mrSel | output | 2 | Index of the register being written |
| addr | output | ADDR_W | Register value during a write, zero otherwise |
| initDone | output | 1 | Device ready for normal operation |

## Verification
The bench drops power-good at every cycle position of the sequence, from the first hold cycle through the ready state, and then runs a complete sequence after each drop. A sequencer that kept a stale counter or state would release reset early or emit a write out of place on the restart. The reset hold uses a period that does not divide the hold time, so a truncating conversion would release reset one cycle too soon. Every window is compared cycle by cycle against arithmetic in the bench, which catches an off-by-one gap, a swapped register order, or a lingering strobe.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

  typedef enum logic [3:0] {
    ST_HOLD,
    ST_PRE,
    ST_POST,
    ST_MR0,
    ST_GAP,
    ST_MR1,
    ST_CAL,
    ST_MR2,
    ST_DONE
  } seqState_t;

  typedef enum logic [2:0] {
    W_HOLD,
    W_PRE,
    W_POST,
    W_GAP,
    W_CAL,
    W_NONE
  } waitSel_t;

  localparam logic [1:0] CMD_NOP = 2'b00;
  localparam logic [1:0] CMD_MRS = 2'b01;
  localparam int NUM_MR = 3;

  typedef struct packed {
    logic       cntClr;
    waitSel_t   waitSel;
    logic       issueMrs;
    logic [1:0] mrIdx;
    logic       releaseReset;
    logic       ready;
  } seqCtl_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/init_seq_datapath.sv
module init_seq_datapath
  import dram_init_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int CNT_W    = 18,
  parameter int HOLD_CYC = 160000,
  parameter int PRE_CYC  = 100,
  parameter int POST_CYC = 10000,
  parameter int GAP_CYC  = 12,
  parameter int CAL_CYC  = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] mr0Val,
  input  logic [ADDR_W-1:0] mr1Val,
  input  logic [ADDR_W-1:0] mr2Val,
  output logic              cntHit,
  output logic              devResetN,
  output logic [1:0]        cmd,
  output logic              cmdValid,
  output logic [1:0]        mrSel,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone
);

  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_CYC - 1);
  localparam logic [CNT_W-1:0] POST_LAST = CNT_W'(POST_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] CAL_LAST  = CNT_W'(CAL_CYC - 1);

  logic [CNT_W-1:0] waitCnt;
  logic [CNT_W-1:0] lastVal;

  // Cycle counter shared by every wait window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           waitCnt <= '0;
    else if (ctl.cntClr) waitCnt <= '0;
    else                 waitCnt <= waitCnt + 1'b1;
  end

  always_comb begin
    lastVal = '0;
    case (ctl.waitSel)
      W_HOLD:  lastVal = HOLD_LAST;
      W_PRE:   lastVal = PRE_LAST;
      W_POST:  lastVal = POST_LAST;
      W_GAP:   lastVal = GAP_LAST;
      W_CAL:   lastVal = CAL_LAST;
      default: lastVal = '0;
    endcase
  end

  assign cntHit = (ctl.waitSel != W_NONE) && (waitCnt == lastVal);

  // Mode-register value selection
  logic [NUM_MR-1:0][ADDR_W-1:0] mrVals;
  logic [NUM_MR-1:0][ADDR_W-1:0] picked;

  assign mrVals[0] = mr0Val;
  assign mrVals[1] = mr1Val;
  assign mrVals[2] = mr2Val;

  for (genvar i = 0; i < NUM_MR; i++) begin : g_pick
    assign picked[i] = (ctl.issueMrs && (ctl.mrIdx == 2'(i))) ? mrVals[i] : '0;
  end

  always_comb begin
    addr = '0;
    for (int j = 0; j < NUM_MR; j++) addr = addr | picked[j];
  end

  assign cmdValid  = ctl.issueMrs;
  assign cmd       = ctl.issueMrs ? CMD_MRS : CMD_NOP;
  assign mrSel     = ctl.issueMrs ? ctl.mrIdx : 2'd0;
  assign devResetN = ctl.releaseReset;
  assign initDone  = ctl.ready;

endmodule

// File: rtl/init_seq_control.sv
module init_seq_control
  import dram_init_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    pwrGood,
  input  logic    cntHit,
  output seqCtl_t ctl
);

  seqState_t state;
  seqState_t nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HOLD;
    else       state <= nxt;
  end

  always_comb begin
    nxt              = state;
    ctl.waitSel      = W_NONE;
    ctl.issueMrs     = 1'b0;
    ctl.mrIdx        = 2'd0;
    ctl.releaseReset = 1'b1;
    ctl.ready        = 1'b0;
    case (state)
      ST_HOLD: begin
        ctl.waitSel      = W_HOLD;
        ctl.releaseReset = 1'b0;
        if (cntHit) nxt = ST_PRE;
      end
      ST_PRE: begin
        ctl.waitSel      = W_PRE;
        ctl.releaseReset = 1'b0;
        if (cntHit) nxt = ST_POST;
      end
      ST_POST: begin
        ctl.waitSel = W_POST;
        if (cntHit) nxt = ST_MR0;
      end
      ST_MR0: begin
        ctl.issueMrs = 1'b1;
        ctl.mrIdx    = 2'd0;
        nxt          = ST_GAP;
      end
      ST_GAP: begin
        ctl.waitSel = W_GAP;
        if (cntHit) nxt = ST_MR1;
      end
      ST_MR1: begin
        ctl.issueMrs = 1'b1;
        ctl.mrIdx    = 2'd1;
        nxt          = ST_CAL;
      end
      ST_CAL: begin
        ctl.waitSel = W_CAL;
        if (cntHit) nxt = ST_MR2;
      end
      ST_MR2: begin
        ctl.issueMrs = 1'b1;
        ctl.mrIdx    = 2'd2;
        nxt          = ST_DONE;
      end
      ST_DONE: begin
        ctl.ready = 1'b1;
      end
      default: begin
        nxt              = ST_HOLD;
        ctl.releaseReset = 1'b0;
      end
    endcase
    if (!pwrGood) nxt = ST_HOLD;
    ctl.cntClr = !pwrGood || (nxt != state) || (ctl.waitSel == W_NONE);
  end

endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dram_init_pkg::*;
#(
  parameter int ADDR_W          = 20,
  parameter int CLK_PERIOD_PS   = 1250,
  parameter int RESET_HOLD_NS   = 200000,
  parameter int PRE_NOP_CYCLES  = 100,
  parameter int POST_NOP_CYCLES = 10000,
  parameter int MRS_GAP_CYCLES  = 12,
  parameter int CAL_CYCLES      = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrGood,
  input  logic [ADDR_W-1:0] mr0Val,
  input  logic [ADDR_W-1:0] mr1Val,
  input  logic [ADDR_W-1:0] mr2Val,
  output logic              devResetN,
  output logic [1:0]        cmd,
  output logic              cmdValid,
  output logic [1:0]        mrSel,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone
);

  localparam int HOLD_CYC = (RESET_HOLD_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int MAX_WAIT = maxOf(maxOf(HOLD_CYC, PRE_NOP_CYCLES),
                                  maxOf(POST_NOP_CYCLES, maxOf(MRS_GAP_CYCLES, CAL_CYCLES)));
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  seqCtl_t ctl;
  logic    cntHit;

  init_seq_control u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .pwrGood(pwrGood),
    .cntHit (cntHit),
    .ctl    (ctl)
  );

  init_seq_datapath #(
    .ADDR_W  (ADDR_W),
    .CNT_W   (CNT_W),
    .HOLD_CYC(HOLD_CYC),
    .PRE_CYC (PRE_NOP_CYCLES),
    .POST_CYC(POST_NOP_CYCLES),
    .GAP_CYC (MRS_GAP_CYCLES),
    .CAL_CYC (CAL_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .mr0Val   (mr0Val),
    .mr1Val   (mr1Val),
    .mr2Val   (mr2Val),
    .cntHit   (cntHit),
    .devResetN(devResetN),
    .cmd      (cmd),
    .cmdValid (cmdValid),
    .mrSel    (mrSel),
    .addr     (addr),
    .initDone (initDone)
  );

endmodule

// File: rtl/init_seq_checker.sv
module init_seq_checker #(
  parameter int ADDR_W  = 20,
  parameter int GAP_CYC = 12,
  parameter int CAL_CYC = 512
) (
  input logic              clk,
  input logic              rstN,
  input logic              pwrGood,
  input logic              devResetN,
  input logic [1:0]        cmd,
  input logic              cmdValid,
  input logic [1:0]        mrSel,
  input logic [ADDR_W-1:0] addr,
  input logic              initDone
);

  logic [31:0] nopRun;
  logic        seen0, seen1, seen2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nopRun <= '0;
      seen0  <= 1'b0;
      seen1  <= 1'b0;
      seen2  <= 1'b0;
    end else begin
      if (cmdValid)                nopRun <= '0;
      else if (nopRun != '1)       nopRun <= nopRun + 1'b1;
      if (!pwrGood) begin
        seen0 <= 1'b0;
        seen1 <= 1'b0;
        seen2 <= 1'b0;
      end else if (cmdValid) begin
        if (mrSel == 2'd0) begin
          seen0 <= 1'b1;
          seen1 <= 1'b0;
          seen2 <= 1'b0;
        end
        if (mrSel == 2'd1) seen1 <= 1'b1;
        if (mrSel == 2'd2) seen2 <= 1'b1;
      end
    end
  end

  p_mrs_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  p_nop_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> (cmd == 2'b00 && addr == '0 && mrSel == 2'd0));

  p_mrs_code_r1: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> cmd == 2'b01);

  p_reset_before_mrs_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> devResetN);

  p_gap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && mrSel == 2'd1) |-> (seen0 && nopRun == 32'(GAP_CYC)));

  p_cal_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && mrSel == 2'd2) |-> (seen1 && nopRun == 32'(CAL_CYC)));

  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && pwrGood) |=> initDone);

  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> (!cmdValid && seen2));

  p_pwr_loss_r8: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |=> (!initDone && !devResetN && !cmdValid));

endmodule

bind dram_init_seq init_seq_checker #(
  .ADDR_W (ADDR_W),
  .GAP_CYC(MRS_GAP_CYCLES),
  .CAL_CYC(CAL_CYCLES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pwrGood  (pwrGood),
  .devResetN(devResetN),
  .cmd      (cmd),
  .cmdValid (cmdValid),
  .mrSel    (mrSel),
  .addr     (addr),
  .initDone (initDone)
);

// File: tb/sim_dram_init_seq.sv
`timescale 1ns/1ps
module sim_dram_init_seq;

  localparam int AW      = 12;
  localparam int PER_PS  = 10000;
  localparam int HOLD_NS = 505;
  localparam int PRE     = 7;
  localparam int POST    = 20;
  localparam int GAP     = 3;
  localparam int CAL     = 9;

  // Expected timeline, in edges counted from the first edge with power good
  localparam int H  = (HOLD_NS * 1000 + PER_PS - 1) / PER_PS;
  localparam int T0 = H + PRE + POST;
  localparam int T1 = T0 + GAP + 1;
  localparam int T2 = T1 + CAL + 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          pwrGood = 1'b0;
  logic [AW-1:0] mr0Val = '0, mr1Val = '0, mr2Val = '0;
  logic          devResetN, cmdValid, initDone;
  logic [1:0]    cmd, mrSel;
  logic [AW-1:0] addr;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  dram_init_seq #(
    .ADDR_W         (AW),
    .CLK_PERIOD_PS  (PER_PS),
    .RESET_HOLD_NS  (HOLD_NS),
    .PRE_NOP_CYCLES (PRE),
    .POST_NOP_CYCLES(POST),
    .MRS_GAP_CYCLES (GAP),
    .CAL_CYCLES     (CAL)
  ) u0 (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood),
    .mr0Val(mr0Val), .mr1Val(mr1Val), .mr2Val(mr2Val),
    .devResetN(devResetN), .cmd(cmd), .cmdValid(cmdValid),
    .mrSel(mrSel), .addr(addr), .initDone(initDone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int k, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s k=%0d actual=%0h expected=%0h", req, what, k, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(devResetN == 1'b0, req, "devResetN", -1, devResetN, 0);
    check(initDone == 1'b0, req, "initDone", -1, initDone, 0);
    check(cmdValid == 1'b0 && cmd == 2'b00, req, "cmd", -1, {cmdValid, cmd}, 0);
  endtask

  task automatic check_cycle(input int k);
    bit            expRst, expValid, expDone;
    logic [1:0]    expSel;
    logic [AW-1:0] expAddr;
    string         seqReq;
    expRst   = (k >= H + PRE);
    expValid = (k == T0) || (k == T1) || (k == T2);
    expSel   = (k == T1) ? 2'd1 : (k == T2) ? 2'd2 : 2'd0;
    expAddr  = (k == T0) ? mr0Val : (k == T1) ? mr1Val : (k == T2) ? mr2Val : '0;
    expDone  = (k > T2);
    seqReq   = (k <= T0) ? "R4" : (k <= T1) ? "R5" : (k <= T2) ? "R6" : "R7";
    check(devResetN == expRst, (k < H) ? "R2" : "R3", "devResetN", k, devResetN, expRst);
    check(cmdValid == expValid, seqReq, "cmdValid", k, cmdValid, expValid);
    check(cmd == (expValid ? 2'b01 : 2'b00), "R1", "cmd", k, cmd, expValid ? 1 : 0);
    check(mrSel == expSel, seqReq, "mrSel", k, mrSel, expSel);
    check(addr == expAddr, seqReq, "addr", k, addr, expAddr);
    check(initDone == expDone, "R7", "initDone", k, initDone, expDone);
  endtask

  // Called at a negedge: raise power and follow the sequence for n edges
  task automatic run_seq(input int n);
    pwrGood = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(posedge clk);
      @(negedge clk);
      check_cycle(k);
    end
  endtask

  task automatic drop_power();
    pwrGood = 1'b0;
    for (int c = 0; c < 2; c++) begin
      @(posedge clk);
      @(negedge clk);
      check_idle("R8");
    end
  endtask

  task automatic set_vals(input int seed);
    mr0Val = AW'(seed * 37 + 12'h5a5);
    mr1Val = AW'(seed * 91 + 12'h0c3);
    mr2Val = AW'(seed * 13 + 12'hf11);
  endtask

  initial begin
    #(1_500_000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog R7 run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R9: reset state, with power good both low and high
    repeat (3) @(negedge clk);
    check_idle("R9");
    pwrGood = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R9");
    pwrGood = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check_idle("R2");

    // Full sequence, long stay in the ready state
    set_vals(1);
    run_seq(T2 + 40);
    drop_power();

    // R8: power loss at every position, then a full restart
    for (int d = 1; d <= T2 + 3; d++) begin
      set_vals(d + 2);
      run_seq(d);
      drop_power();
      set_vals(d * 5 + 1);
      run_seq(T2 + 3);
      drop_power();
    end

    // All-ones and all-zeros register values
    mr0Val = '1; mr1Val = '0; mr2Val = '1;
    run_seq(T2 + 5);
    drop_power();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule